// File: doc/BRIEF.md
# Paged Address Translation and Protection Unit

This block sits between a 16-bit processor and on-board RAM. The RAM is split into 1024 pages of 256 bytes. On every processor access, the block looks up the logical page number in a remap table. It replaces that page number with the physical page number it finds there, and checks the per-page read and write permissions. Scattered physical pages can therefore look like one contiguous logical region to software.

An access that breaks a page's permission does not reach memory. The block raises a bus-error signal to the processor and withholds the memory chip enable and write enable, so protected data cannot change. The table is programmed through a one-cycle configuration write port. Until an entry is written, it maps its page to the same physical page with both reads and writes allowed, so boot code can run before any programming. The decision for an access is frozen when its strobe first rises. A table write made during an access therefore only affects later accesses.

Top module: `page_guard`

## Requirements
- R1: After reset, every page maps to the physical page with the same number, and both reads and writes are permitted.
- R2: The low 8 bits of `cpuAddr` (the byte offset within a page) appear unchanged on the low 8 bits of `memAddr`.
- R3: `memAddr[17:8]` carries the physical page stored for logical page `cpuAddr[17:8]`. Two different logical pages can map to arbitrary physical pages.
- R4: A read (`cpuRead`=1) to a page whose read permission is 0 raises `busErr` in the same cycle as `cpuStrobe`, and `memCe` stays 0.
- R5: A write (`cpuRead`=0) to a page whose write permission is 0 raises `busErr` in the same cycle as `cpuStrobe`, and `memCe` and `memWe` stay 0.
- R6: Read and write permissions are independent. A read-protected page still accepts writes, and a write-protected page still accepts reads.
- R7: Once raised, `busErr` stays high for as long as `cpuStrobe` is held. It drops in the cycle in which `cpuStrobe` is low.
- R8: A configuration write (`cfgWe`=1 for one cycle) is visible from the next access. An access already in progress keeps the mapping and permissions it started with.
- R9: `memWdata` follows `cpuWdata`, and `cpuRdata` follows `memRdata`.
- R10: `memWe` is high only during a permitted write, and `memCe` is high only during a permitted access while `cpuStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 18 | Logical byte address: page number in 17:8, offset in 7:0 |
| cpuStrobe | input | 1 | Access strobe, held high for the whole access |
| cpuRead | input | 1 | 1 = read, 0 = write |
| cpuWdata | input | 16 | Write data from processor |
| cpuRdata | output | 16 | Read data to processor |
| busErr | output | 1 | Protection violation indication |
| memAddr | output | 18 | Physical byte address |
| memCe | output | 1 | Memory chip enable |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 16 | Write data to memory |
| memRdata | input | 16 | Read data from memory |
| cfgWe | input | 1 | Table entry write strobe |
| cfgPage | input | 10 | Logical page index being programmed |
| cfgPhys | input | 10 | Physical page for that entry |
| cfgRdOk | input | 1 | Read permission for that entry (1 = allowed) |
| cfgWrOk | input | 1 | Write permission for that entry (1 = allowed) |

## Verification
The assertions assume that the processor holds `cpuAddr` and `cpuRead` steady while `cpuStrobe` is high. They also assume that every access ends with at least one cycle of `cpuStrobe` low before the next one begins. The checks of held error and frozen mapping rely on both assumptions. The stimulus changes address and direction only in cycles where the strobe is low, and always inserts an idle cycle between accesses. Configuration writes are issued both between accesses and during a held access, to exercise the frozen decision.

// File: rtl/page_guard_pkg.sv
package page_guard_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } acc_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // first cycle of an access: latch the live lookup
    logic active;   // later cycles of an access: use latched lookup
  } acc_ctl_t;

endpackage

// File: rtl/page_guard_table.sv
module page_guard_table #(
  parameter int PAGE_W = 10,
  parameter int PHYS_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PAGE_W-1:0] cfgPage,
  input  logic [PHYS_W-1:0] cfgPhys,
  input  logic              cfgRdOk,
  input  logic              cfgWrOk,
  input  logic [PAGE_W-1:0] lkPage,
  output logic [PHYS_W-1:0] lkPhys,
  output logic              lkRdOk,
  output logic              lkWrOk
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int ENT_W = PHYS_W + 2;

  logic [ENT_W-1:0] store [PAGES];
  logic [PAGES-1:0] programmed;
  logic [ENT_W-1:0] rdEntry;

  // entry storage carries no reset; the programmed bit chooses it
  always_ff @(posedge clk) begin
    if (cfgWe) store[cfgPage] <= {cfgPhys, cfgRdOk, cfgWrOk};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      programmed <= '0;
    else if (cfgWe) programmed[cfgPage] <= 1'b1;
  end

  always_comb begin
    rdEntry = store[lkPage];
    if (programmed[lkPage]) begin
      lkPhys = rdEntry[ENT_W-1:2];
      lkRdOk = rdEntry[1];
      lkWrOk = rdEntry[0];
    end else begin
      lkPhys = PHYS_W'(lkPage);  // identity after reset
      lkRdOk = 1'b1;
      lkWrOk = 1'b1;
    end
  end

  p_entry_marked_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> programmed[$past(cfgPage)]);

endmodule

// File: rtl/page_guard_ctrl.sv
module page_guard_ctrl
  import page_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuStrobe,
  output acc_ctl_t ctl
);
  acc_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cpuStrobe)  stateNext = ST_BUSY;
      ST_BUSY: if (!cpuStrobe) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ctl.capture = (state == ST_IDLE) && cpuStrobe;
  assign ctl.active  = (state == ST_BUSY);

  p_busy_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> $past(cpuStrobe));

endmodule

// File: rtl/page_guard_dp.sv
module page_guard_dp
  import page_guard_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int PHYS_W = 10,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int MEM_W  = PHYS_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  acc_ctl_t          ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuStrobe,
  input  logic              cpuRead,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busErr,
  input  logic [PHYS_W-1:0] lkPhys,
  input  logic              lkRdOk,
  input  logic              lkWrOk,
  output logic [PAGE_W-1:0] lkPage,
  output logic [MEM_W-1:0]  memAddr,
  output logic              memCe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  logic [PHYS_W-1:0] heldPhys;
  logic              heldRdOk, heldWrOk;
  logic [PHYS_W-1:0] curPhys;
  logic              curRdOk, curWrOk, permitted;

  assign lkPage = cpuAddr[ADDR_W-1:OFF_W];

  // freeze the decision at the first cycle of an access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldPhys <= '0;
      heldRdOk <= 1'b0;
      heldWrOk <= 1'b0;
    end else if (ctl.capture) begin
      heldPhys <= lkPhys;
      heldRdOk <= lkRdOk;
      heldWrOk <= lkWrOk;
    end
  end

  always_comb begin
    if (ctl.active) begin
      curPhys = heldPhys;
      curRdOk = heldRdOk;
      curWrOk = heldWrOk;
    end else begin
      curPhys = lkPhys;
      curRdOk = lkRdOk;
      curWrOk = lkWrOk;
    end
    permitted = cpuRead ? curRdOk : curWrOk;
  end

  assign memAddr  = {curPhys, cpuAddr[OFF_W-1:0]};
  assign busErr   = cpuStrobe & ~permitted;
  assign memCe    = cpuStrobe & permitted;
  assign memWe    = memCe & ~cpuRead;
  assign memWdata = cpuWdata;
  assign cpuRdata = memRdata;

  p_held_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && cpuStrobe) |=> $stable(heldPhys) && $stable(heldRdOk) && $stable(heldWrOk));

  p_no_write_on_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> !memWe && !memCe);

endmodule

// File: rtl/page_guard.sv
module page_guard
  import page_guard_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int PHYS_W = 10,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int MEM_W  = PHYS_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuStrobe,
  input  logic              cpuRead,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busErr,
  output logic [MEM_W-1:0]  memAddr,
  output logic              memCe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              cfgWe,
  input  logic [PAGE_W-1:0] cfgPage,
  input  logic [PHYS_W-1:0] cfgPhys,
  input  logic              cfgRdOk,
  input  logic              cfgWrOk
);
  acc_ctl_t          ctl;
  logic [PAGE_W-1:0] lkPage;
  logic [PHYS_W-1:0] lkPhys;
  logic              lkRdOk, lkWrOk;

  page_guard_table #(.PAGE_W(PAGE_W), .PHYS_W(PHYS_W)) uTable (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgPage(cfgPage), .cfgPhys(cfgPhys),
    .cfgRdOk(cfgRdOk), .cfgWrOk(cfgWrOk),
    .lkPage(lkPage), .lkPhys(lkPhys), .lkRdOk(lkRdOk), .lkWrOk(lkWrOk)
  );

  page_guard_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuStrobe(cpuStrobe), .ctl(ctl)
  );

  page_guard_dp #(.PAGE_W(PAGE_W), .PHYS_W(PHYS_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cpuAddr(cpuAddr), .cpuStrobe(cpuStrobe), .cpuRead(cpuRead),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .busErr(busErr),
    .lkPhys(lkPhys), .lkRdOk(lkRdOk), .lkWrOk(lkWrOk), .lkPage(lkPage),
    .memAddr(memAddr), .memCe(memCe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  p_err_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> busErr || !cpuStrobe);

  p_no_we_on_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuRead |-> !memWe);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuStrobe |-> memAddr[OFF_W-1:0] == cpuAddr[OFF_W-1:0]);

endmodule

// File: tb/tb_page_guard.sv
`timescale 1ns/1ps
module tb_page_guard;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] cpuAddr = '0;
  logic        cpuStrobe = 1'b0, cpuRead = 1'b1;
  logic [15:0] cpuWdata = '0, memRdata = '0;
  logic [15:0] cpuRdata, memWdata;
  logic        busErr, memCe, memWe;
  logic [17:0] memAddr;
  logic        cfgWe = 1'b0, cfgRdOk = 1'b0, cfgWrOk = 1'b0;
  logic [9:0]  cfgPage = '0, cfgPhys = '0;

  page_guard dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    logic        strobe, ce, we, err;
    logic [17:0] addr;
    string       req;
  } exp_t;

  exp_t q[$];
  event chk;
  int   nRun = 0, nFail = 0;
  bit   done = 1'b0;

  logic [9:0] mPhys [1024];
  logic       mRd [1024];
  logic       mWr [1024];

  // monitor: pops one expected item per driven cycle
  initial begin
    forever begin
      @(chk);
      #3;
      begin
        exp_t e;
        e = q.pop_front();
        nRun++;
        if (busErr !== e.err || memCe !== e.ce || memWe !== e.we ||
            (e.strobe && memAddr !== e.addr) ||
            memWdata !== cpuWdata || cpuRdata !== memRdata) begin
          nFail++;
          $display("FAIL %s: err/ce/we/addr/wd/rd = %b/%b/%b/%h/%h/%h expected %b/%b/%b/%h/%h/%h",
                   e.req, busErr, memCe, memWe, memAddr, memWdata, cpuRdata,
                   e.err, e.ce, e.we, e.addr, cpuWdata, memRdata);
        end
      end
    end
  end

  task automatic cfgWrite(input logic [9:0] pg, input logic [9:0] ph, input logic rd, input logic wr);
    @(negedge clk);
    cfgWe = 1'b1; cfgPage = pg; cfgPhys = ph; cfgRdOk = rd; cfgWrOk = wr;
    mPhys[pg] = ph; mRd[pg] = rd; mWr[pg] = wr;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one access held for 'hold' cycles, then one idle cycle.
  // midCfg: reprogram the accessed page in the second cycle (R8).
  task automatic access(input logic [9:0] pg, input logic [7:0] off, input logic rd,
                        input int hold, input string req,
                        input bit midCfg = 0, input logic midRd = 1, input logic midWr = 1);
    exp_t e;
    logic ok;
    ok = rd ? mRd[pg] : mWr[pg];
    e.strobe = 1'b1; e.ce = ok; e.we = ok & ~rd; e.err = ~ok;
    e.addr = {mPhys[pg], off}; e.req = req;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      cpuStrobe = 1'b1; cpuAddr = {pg, off}; cpuRead = rd;
      cpuWdata = 16'h1357 ^ {6'd0, pg} ^ 16'(i);
      memRdata = 16'hC0DE + 16'(i);
      if (midCfg && i == 1) begin
        cfgWe = 1'b1; cfgPage = pg; cfgPhys = ~pg; cfgRdOk = midRd; cfgWrOk = midWr;
      end else begin
        cfgWe = 1'b0;
      end
      q.push_back(e);
      ->chk;
    end
    if (midCfg) begin
      mPhys[pg] = ~pg; mRd[pg] = midRd; mWr[pg] = midWr;
    end
    @(negedge clk);
    cpuStrobe = 1'b0; cfgWe = 1'b0;
    e.strobe = 1'b0; e.ce = 1'b0; e.we = 1'b0; e.err = 1'b0;
    e.req = {req, " idle"};
    q.push_back(e);
    ->chk;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mPhys[i] = 10'(i); mRd[i] = 1'b1; mWr[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, identity and full permission, boundary pages
    access(10'h005, 8'h00, 1'b1, 1, "R1 read p005");
    access(10'h3FF, 8'hFF, 1'b0, 1, "R1 write p3FF");
    access(10'h000, 8'h01, 1'b0, 2, "R1 write p000");

    // R2/R3: remap, offset passes unchanged
    cfgWrite(10'h003, 10'h2A0, 1'b1, 1'b1);
    access(10'h003, 8'h7E, 1'b1, 1, "R2 R3 read remapped");
    access(10'h003, 8'h81, 1'b0, 1, "R3 R10 write remapped");

    // R3: contiguous logical pages over scattered physical pages
    cfgWrite(10'h010, 10'h200, 1'b1, 1'b1);
    cfgWrite(10'h011, 10'h050, 1'b1, 1'b1);
    access(10'h010, 8'hFF, 1'b1, 1, "R3 contiguous low");
    access(10'h011, 8'h00, 1'b1, 1, "R3 contiguous high");

    // R4/R7: read-protected page, held strobe; R6 write still allowed
    cfgWrite(10'h004, 10'h011, 1'b0, 1'b1);
    access(10'h004, 8'h10, 1'b1, 3, "R4 R7 read protect");
    access(10'h004, 8'h12, 1'b0, 1, "R6 write on read-protected");

    // R5/R7: write-protected page; R6 read still allowed
    cfgWrite(10'h006, 10'h100, 1'b1, 1'b0);
    access(10'h006, 8'h20, 1'b0, 2, "R5 R7 write protect");
    access(10'h006, 8'h22, 1'b1, 1, "R6 read on write-protected");

    // R8: reprogramming during an access does not touch it, applies next
    access(10'h020, 8'h33, 1'b1, 3, "R8 frozen access", 1'b1, 1'b0, 1'b1);
    access(10'h020, 8'h34, 1'b1, 1, "R8 next access sees update");
    access(10'h020, 8'h35, 1'b0, 1, "R8 R9 next write remapped");

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule